// File: doc/BRIEF.md
# Delayed-Start Byte Copy Engine

The block moves a run of bytes between an on-chip scratch buffer and a host memory reached over a simple request/acknowledge byte port. Software programs a source address, a destination address and a byte count, then writes the command register with its run bit set. The engine waits a fixed number of cycles, checks that the buffer side of the copy lies wholly inside the scratch window, and then copies one byte at a time. Host-side addresses are masked to a configurable width. The buffer keeps a second port so the rest of the chip can fill it or drain it.

The sequencer has eight states. `XS_IDLE` goes to `XS_WAIT` on a launch. `XS_WAIT` counts `START_DELAY` cycles and then goes to `XS_CHECK`. `XS_CHECK` goes to `XS_DONE` when the window test fails or the count is zero. Otherwise it goes to `XS_LRD` when copying buffer to host, or to `XS_HRD` when copying host to buffer. In the outbound direction, `XS_LRD` reads the buffer and goes to `XS_HWR`, which holds a host write until it is acknowledged and then goes back to `XS_LRD` or on to `XS_DONE` after the last byte. In the inbound direction, `XS_HRD` holds a host read until it is acknowledged and then goes to `XS_LWR`, which writes the byte into the buffer and goes back to `XS_HRD` or on to `XS_DONE`. `XS_DONE` clears the run bit, pulses the interrupt if it is enabled, and returns to `XS_IDLE`.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, all four registers read zero (select 0 source, 1 destination, 2 count, 3 command), and `host_req` and `irq_pulse` are low.
- R2: Writing select 3 with bit 0 set while idle launches a copy. Command bit 0 then reads 1 until the copy ends and reads 0 afterwards.
- R3: Command bit 1 picks the direction: 0 copies buffer to host, 1 copies host to buffer. Byte k moves between buffer index (buffer-side address − `BASE` + k) and host address ((host-side register + k) AND mask). The buffer-side address is the source register when bit 1 is 0 and the destination register when bit 1 is 1.
- R4: Register writes of any select are ignored while command bit 0 is 1. Reads still return the held values.
- R5: The first host request is seen exactly `START_DELAY`+1 clock edges after the launching edge for host-to-buffer copies, and `START_DELAY`+2 edges after it for buffer-to-host copies.
- R6: `host_addr` bits at and above `MASK_BITS` are zero whenever `host_req` is high.
- R7: If the buffer-side address is below `BASE`, or offset + count exceeds `DEPTH`, the copy aborts. No host request is made, no buffer byte changes, command bit 3 (error) reads 1 and bit 0 reads 0. The next launch clears bit 3. A window that ends exactly at `DEPTH` is accepted.
- R8: With command bit 2 set, each finished or aborted copy gives exactly one one-cycle `irq_pulse`, with `irq_cause` bit 0 = 1 (done) and bit 1 = error. With command bit 2 clear, there is no pulse.
- R9: `host_req`, `host_we`, `host_addr` and `host_wdata` hold steady until `host_ack`.
- R10: A zero count finishes without any host request and without setting the error bit.
- R11: The chip-side buffer port writes on `buf_wr` and returns `buf_rdata` for `buf_addr` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data for `cfg_sel` (combinational) |
| host_req | output | 1 | Host byte access request |
| host_we | output | 1 | 1 = write, 0 = read |
| host_addr | output | AW | Masked host byte address |
| host_wdata | output | 8 | Host write byte |
| host_ack | input | 1 | Host access complete |
| host_rdata | input | 8 | Host read byte, valid with `host_ack` |
| buf_wr | input | 1 | Chip-side buffer write |
| buf_addr | input | LAW | Chip-side buffer index |
| buf_wdata | input | 8 | Chip-side buffer write byte |
| buf_rdata | output | 8 | Chip-side buffer read byte (one-cycle latency) |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_cause | output | 2 | Cause bits, valid with `irq_pulse` |

## Verification
The first host request after a launch is due exactly `START_DELAY`+1 or `START_DELAY`+2 edges after the launching edge. The bench stamps the launching edge with a free-running cycle count and compares the stamp of the first request against that figure. Register reads are combinational, so they are sampled one time unit after the negative edge. Buffer reads are sampled at the negative edge that follows the capturing edge. Interrupt pulses are counted at every negative edge and checked only after the command register's run bit reads 0, so no pulse can still be in flight when the count is compared.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_WAIT,
        XS_CHECK,
        XS_LRD,
        XS_HWR,
        XS_HRD,
        XS_LWR,
        XS_DONE
    } xfer_state_e;

    typedef enum logic [1:0] {
        RSEL_SRC = 2'd0,
        RSEL_DST = 2'd1,
        RSEL_CNT = 2'd2,
        RSEL_CMD = 2'd3
    } reg_sel_e;

    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 1;
    localparam int CMD_IRQ_BIT = 2;
    localparam int CMD_ERR_BIT = 3;

    localparam int CAUSE_DONE_BIT = 0;
    localparam int CAUSE_ERR_BIT  = 1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_copy_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          xfer_done,
    input  logic          xfer_err,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [AW-1:0] cnt_q,
    output logic          dir_q,
    output logic          irq_en_q,
    output logic          run_q,
    output logic          err_q,
    output logic          launch
);

    logic wr_open;

    assign wr_open = cfg_wr && !run_q;
    assign launch  = wr_open && (reg_sel_e'(cfg_sel) == RSEL_CMD) && cfg_wdata[CMD_RUN_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            dir_q    <= 1'b0;
            irq_en_q <= 1'b0;
            run_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (wr_open) begin
                unique case (reg_sel_e'(cfg_sel))
                    RSEL_SRC: src_q <= cfg_wdata;
                    RSEL_DST: dst_q <= cfg_wdata;
                    RSEL_CNT: cnt_q <= cfg_wdata;
                    RSEL_CMD: begin
                        dir_q    <= cfg_wdata[CMD_DIR_BIT];
                        irq_en_q <= cfg_wdata[CMD_IRQ_BIT];
                        run_q    <= cfg_wdata[CMD_RUN_BIT];
                        if (cfg_wdata[CMD_RUN_BIT]) begin
                            err_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (xfer_err) begin
                err_q <= 1'b1;
            end
            if (xfer_done) begin
                run_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (reg_sel_e'(cfg_sel))
            RSEL_SRC: cfg_rdata = src_q;
            RSEL_DST: cfg_rdata = dst_q;
            RSEL_CNT: cfg_rdata = cnt_q;
            RSEL_CMD: begin
                cfg_rdata[CMD_RUN_BIT] = run_q;
                cfg_rdata[CMD_DIR_BIT] = dir_q;
                cfg_rdata[CMD_IRQ_BIT] = irq_en_q;
                cfg_rdata[CMD_ERR_BIT] = err_q;
            end
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_local_buf.sv
module dma_local_buf #(
    parameter int DEPTH = 4096,
    localparam int LAW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LAW-1:0] a_addr,
    input  logic           a_re,
    input  logic           a_we,
    input  logic [7:0]     a_wdata,
    output logic [7:0]     a_rdata,
    input  logic [LAW-1:0] b_addr,
    input  logic           b_we,
    input  logic [7:0]     b_wdata,
    output logic [7:0]     b_rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_re) begin
                a_rdata <= mem[a_addr];
            end
            b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_copy_pkg::*;
#(
    parameter int             AW          = 32,
    parameter int             MASK_BITS   = 28,
    parameter int             DEPTH       = 4096,
    parameter logic [AW-1:0]  BASE        = 'h4_0000,
    parameter int             START_DELAY = 100,
    localparam int            LAW         = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic [AW-1:0]  src,
    input  logic [AW-1:0]  dst,
    input  logic [AW-1:0]  cnt,
    input  logic           dir,
    output logic           host_req,
    output logic           host_we,
    output logic [AW-1:0]  host_addr,
    output logic [7:0]     host_wdata,
    input  logic           host_ack,
    input  logic [7:0]     host_rdata,
    output logic [LAW-1:0] lbuf_addr,
    output logic           lbuf_re,
    output logic           lbuf_we,
    output logic [7:0]     lbuf_wdata,
    input  logic [7:0]     lbuf_rdata,
    output logic           done,
    output logic           err_set
);

    localparam int            DW       = $clog2(START_DELAY + 1);
    localparam int            EW       = AW + 2;
    localparam logic [DW-1:0] DLY_LAST = DW'(START_DELAY - 1);
    localparam logic [AW-1:0] HMASK    = (MASK_BITS >= AW) ? '1
                                       : AW'((64'd1 << MASK_BITS) - 64'd1);

    xfer_state_e state_q, state_d;

    logic [DW-1:0]  dly_q;
    logic [AW-1:0]  idx_q;
    logic [LAW-1:0] lp_q;
    logic [AW-1:0]  hp_q;
    logic [7:0]     byte_q;

    logic [AW-1:0]  loc_start, host_start;
    logic [EW-1:0]  loc_x, off_x, end_x;
    logic           in_range, cnt_zero, last_byte;

    always_comb begin
        loc_start  = dir ? dst : src;
        host_start = dir ? src : dst;
        loc_x      = {2'b00, loc_start};
        off_x      = loc_x - {2'b00, BASE};
        end_x      = off_x + {2'b00, cnt};
        in_range   = (loc_x >= {2'b00, BASE}) && (end_x <= EW'(DEPTH));
        cnt_zero   = (cnt == '0);
        last_byte  = (idx_q == cnt - AW'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:  if (launch) state_d = XS_WAIT;
            XS_WAIT:  if (dly_q == DLY_LAST) state_d = XS_CHECK;
            XS_CHECK: begin
                if (!in_range || cnt_zero) state_d = XS_DONE;
                else if (dir)              state_d = XS_HRD;
                else                       state_d = XS_LRD;
            end
            XS_LRD:   state_d = XS_HWR;
            XS_HWR:   if (host_ack) state_d = last_byte ? XS_DONE : XS_LRD;
            XS_HRD:   if (host_ack) state_d = XS_LWR;
            XS_LWR:   state_d = last_byte ? XS_DONE : XS_HRD;
            XS_DONE:  state_d = XS_IDLE;
            default:  state_d = XS_IDLE;
        endcase
    end

    // datapath counters and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= '0;
            idx_q  <= '0;
            lp_q   <= '0;
            hp_q   <= '0;
            byte_q <= '0;
        end else begin
            unique case (state_q)
                XS_IDLE:  dly_q <= '0;
                XS_WAIT:  dly_q <= dly_q + DW'(1);
                XS_CHECK: begin
                    idx_q <= '0;
                    lp_q  <= off_x[LAW-1:0];
                    hp_q  <= host_start;
                end
                XS_HWR: begin
                    if (host_ack) begin
                        idx_q <= idx_q + AW'(1);
                        lp_q  <= lp_q + LAW'(1);
                        hp_q  <= hp_q + AW'(1);
                    end
                end
                XS_HRD: begin
                    if (host_ack) begin
                        byte_q <= host_rdata;
                    end
                end
                XS_LWR: begin
                    idx_q <= idx_q + AW'(1);
                    lp_q  <= lp_q + LAW'(1);
                    hp_q  <= hp_q + AW'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        host_req   = (state_q == XS_HWR) || (state_q == XS_HRD);
        host_we    = (state_q == XS_HWR);
        host_addr  = hp_q & HMASK;
        host_wdata = lbuf_rdata;
        lbuf_addr  = lp_q;
        lbuf_re    = (state_q == XS_LRD);
        lbuf_we    = (state_q == XS_LWR);
        lbuf_wdata = byte_q;
        done       = (state_q == XS_DONE);
        err_set    = (state_q == XS_CHECK) && !in_range;
    end

endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
    import dma_copy_pkg::*;
#(
    parameter int             AW          = 32,
    parameter int             MASK_BITS   = 28,
    parameter int             DEPTH       = 4096,
    parameter logic [AW-1:0]  BASE        = 'h4_0000,
    parameter int             START_DELAY = 100,
    localparam int            LAW         = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic [AW-1:0]  cfg_rdata,
    output logic           host_req,
    output logic           host_we,
    output logic [AW-1:0]  host_addr,
    output logic [7:0]     host_wdata,
    input  logic           host_ack,
    input  logic [7:0]     host_rdata,
    input  logic           buf_wr,
    input  logic [LAW-1:0] buf_addr,
    input  logic [7:0]     buf_wdata,
    output logic [7:0]     buf_rdata,
    output logic           irq_pulse,
    output logic [1:0]     irq_cause
);

    logic [AW-1:0]  src_q, dst_q, cnt_q;
    logic           dir_q, irq_en_q, run_q, err_q, launch;
    logic           xfer_done, xfer_err;
    logic [LAW-1:0] lb_addr;
    logic           lb_re, lb_we;
    logic [7:0]     lb_wdata, lb_rdata;

    dma_cfg_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .xfer_done (xfer_done),
        .xfer_err  (xfer_err),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .dir_q     (dir_q),
        .irq_en_q  (irq_en_q),
        .run_q     (run_q),
        .err_q     (err_q),
        .launch    (launch)
    );

    dma_xfer_fsm #(
        .AW          (AW),
        .MASK_BITS   (MASK_BITS),
        .DEPTH       (DEPTH),
        .BASE        (BASE),
        .START_DELAY (START_DELAY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .src        (src_q),
        .dst        (dst_q),
        .cnt        (cnt_q),
        .dir        (dir_q),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .lbuf_addr  (lb_addr),
        .lbuf_re    (lb_re),
        .lbuf_we    (lb_we),
        .lbuf_wdata (lb_wdata),
        .lbuf_rdata (lb_rdata),
        .done       (xfer_done),
        .err_set    (xfer_err)
    );

    dma_local_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_addr  (lb_addr),
        .a_re    (lb_re),
        .a_we    (lb_we),
        .a_wdata (lb_wdata),
        .a_rdata (lb_rdata),
        .b_addr  (buf_addr),
        .b_we    (buf_wr),
        .b_wdata (buf_wdata),
        .b_rdata (buf_rdata)
    );

    always_comb begin
        irq_pulse = xfer_done && irq_en_q;
        irq_cause = '0;
        if (irq_pulse) begin
            irq_cause[CAUSE_DONE_BIT] = 1'b1;
            irq_cause[CAUSE_ERR_BIT]  = err_q;
        end
    end

endmodule

// File: rtl/dma_copy_engine_chk.sv
module dma_copy_engine_chk #(
    parameter int AW          = 32,
    parameter int MASK_BITS   = 28,
    parameter int START_DELAY = 100
) (
    input logic          clk,
    input logic          rst_n,
    input logic          launch,
    input logic          run_q,
    input logic          irq_en_q,
    input logic          cfg_wr,
    input logic [AW-1:0] src_q,
    input logic [AW-1:0] dst_q,
    input logic [AW-1:0] cnt_q,
    input logic          host_req,
    input logic          host_we,
    input logic          host_ack,
    input logic [AW-1:0] host_addr,
    input logic [7:0]    host_wdata,
    input logic          irq_pulse,
    input logic [1:0]    irq_cause
);

    localparam int            SW    = $clog2(START_DELAY + 3);
    localparam logic [SW-1:0] S_TOP = SW'(START_DELAY + 1);
    localparam logic [AW-1:0] HMASK = (MASK_BITS >= AW) ? '1
                                    : AW'((64'd1 << MASK_BITS) - 64'd1);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= '0;
        else if (launch)           since_q <= '0;
        else if (since_q != S_TOP) since_q <= since_q + SW'(1);
    end

    p_no_req_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !host_req);

    p_run_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !run_q);

    p_regs_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cfg_wr) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

    p_start_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> (since_q > SW'(START_DELAY)));

    p_addr_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |-> ((host_addr & ~HMASK) == '0));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (irq_en_q && irq_cause[0]));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> (host_req && $stable(host_addr)
                                     && $stable(host_we) && $stable(host_wdata)));

endmodule

bind dma_copy_engine dma_copy_engine_chk #(
    .AW          (AW),
    .MASK_BITS   (MASK_BITS),
    .START_DELAY (START_DELAY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .run_q      (run_q),
    .irq_en_q   (irq_en_q),
    .cfg_wr     (cfg_wr),
    .src_q      (src_q),
    .dst_q      (dst_q),
    .cnt_q      (cnt_q),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_ack   (host_ack),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .irq_pulse  (irq_pulse),
    .irq_cause  (irq_cause)
);

// File: tb/sim_dma_copy_engine.sv
module sim_dma_copy_engine;

    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam int          MB         = 16;
    localparam int          DEPTH      = 256;
    localparam int          D          = 8;
    localparam logic [31:0] BASE       = 32'h0000_8000;
    localparam logic [31:0] JUNK       = 32'hF5A0_0000;

    logic        clk, rst_n;
    logic        cfg_wr;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        host_req, host_we, host_ack;
    logic [31:0] host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        buf_wr;
    logic [7:0]  buf_addr, buf_wdata, buf_rdata;
    logic        irq_pulse;
    logic [1:0]  irq_cause;

    dma_copy_engine #(
        .AW(AW), .MASK_BITS(MB), .DEPTH(DEPTH), .BASE(BASE), .START_DELAY(D)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .irq_pulse(irq_pulse), .irq_cause(irq_cause)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int wr_cyc = 0;
    int first_req = -1;
    int irq_cnt = 0;
    logic [1:0] last_cause = 2'b00;
    int bad_addr = 0;
    logic [7:0] hmem [1024];

    always @(posedge clk) cyc <= cyc + 1;

    // host memory responder: ack one cycle after a request is seen
    always @(posedge clk) begin
        if (!rst_n) begin
            host_ack <= 1'b0;
        end else if (host_req && !host_ack) begin
            host_ack <= 1'b1;
            if (host_addr[31:MB] != 0) bad_addr <= bad_addr + 1;
            if (host_we) hmem[host_addr[9:0]] <= host_wdata;
            host_rdata <= hmem[host_addr[9:0]];
        end else begin
            host_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (host_req && first_req < 0) first_req = cyc;
        if (irq_pulse) begin
            irq_cnt = irq_cnt + 1;
            last_cause = irq_cause;
        end
    end

    function automatic logic [7:0] lpat(int i, int s);
        return 8'(i * 29 + 7 + s);
    endfunction

    function automatic logic [7:0] hpat(int a, int s);
        return 8'(a * 13 + 91 + s);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic cfg_read(logic [1:0] sel, output logic [31:0] v);
        @(negedge clk);
        cfg_sel = sel;
        #1 v = cfg_rdata;
    endtask

    task automatic buf_put(int a, logic [7:0] d);
        @(negedge clk);
        buf_wr = 1'b1; buf_addr = 8'(a); buf_wdata = d;
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    task automatic buf_get(int a, output logic [7:0] v);
        @(negedge clk);
        buf_addr = 8'(a);
        @(negedge clk);
        v = buf_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do cfg_read(2'd3, v); while (v[0]);
    endtask

    task automatic prefill(int seed);
        for (int i = 0; i < DEPTH; i++) buf_put(i, lpat(i, seed));
        for (int a = 0; a < 1024; a++) hmem[a] = hpat(a, seed);
    endtask

    // program and launch; returns after run bit clears
    task automatic launch(bit dir, bit irq, logic [31:0] loc, logic [31:0] hst,
                          logic [31:0] len, bit poke, output int c0);
        logic [31:0] v;
        cfg_write(2'd0, dir ? hst : loc);
        cfg_write(2'd1, dir ? loc : hst);
        cfg_write(2'd2, len);
        first_req = -1;
        irq_cnt = 0;
        cfg_write(2'd3, {29'd0, irq, dir, 1'b1});
        c0 = wr_cyc;
        if (poke) begin
            cfg_write(2'd0, 32'h0);
            cfg_write(2'd2, 32'd5);
            cfg_write(2'd3, 32'h0);
            cfg_read(2'd0, v);
            check("R4 src frozen", v, dir ? hst : loc);
            cfg_read(2'd2, v);
            check("R4 count frozen", v, len);
            cfg_read(2'd3, v);
            check("R4 run kept", {31'd0, v[0]}, 32'd1);
        end
        wait_idle();
    endtask

    task automatic run_ok(bit dir, bit irq, int loc_off, int host_off, int len, int seed, bit poke);
        int c0;
        logic [31:0] v;
        logic [7:0] b;
        prefill(seed);
        launch(dir, irq, BASE + 32'(loc_off), JUNK | 32'(host_off), 32'(len), poke, c0);
        if (len > 0)
            check("R5 first request edge", 32'(first_req - c0), dir ? 32'(D + 1) : 32'(D + 2));
        else
            check("R10 no host request", 32'(first_req), 32'hFFFF_FFFF);
        check("R8 irq count", 32'(irq_cnt), {31'd0, irq});
        if (irq) check("R8 irq cause", {30'd0, last_cause}, 32'd1);
        cfg_read(2'd3, v);
        check("R2 command after end", v, {28'd0, 1'b0, irq, dir, 1'b0});
        if (!dir) begin
            for (int k = 0; k < len; k++)
                check("R3 host byte", {24'd0, hmem[host_off + k]}, {24'd0, lpat(loc_off + k, seed)});
            check("R3 host neighbour", {24'd0, hmem[host_off + len]}, {24'd0, hpat(host_off + len, seed)});
        end else begin
            for (int k = 0; k < len; k++) begin
                buf_get(loc_off + k, b);
                check("R3 buffer byte", {24'd0, b}, {24'd0, hpat(host_off + k, seed)});
            end
            if (loc_off + len < DEPTH) begin
                buf_get(loc_off + len, b);
                check("R3 buffer neighbour", {24'd0, b}, {24'd0, lpat(loc_off + len, seed)});
            end
        end
    endtask

    task automatic run_bad(bit dir, logic [31:0] loc, int host_off, logic [31:0] len, int seed);
        int c0;
        logic [31:0] v;
        logic [7:0] b;
        prefill(seed);
        launch(dir, 1'b1, loc, JUNK | 32'(host_off), len, 1'b0, c0);
        check("R7 no host request", 32'(first_req), 32'hFFFF_FFFF);
        cfg_read(2'd3, v);
        check("R7 error set run clear", {30'd0, v[3], v[0]}, 32'd2);
        check("R8 irq count on abort", 32'(irq_cnt), 32'd1);
        check("R8 irq cause on abort", {30'd0, last_cause}, 32'd3);
        buf_get(0, b);
        check("R7 buffer untouched", {24'd0, b}, {24'd0, lpat(0, seed)});
        buf_get(DEPTH - 1, b);
        check("R7 buffer untouched end", {24'd0, b}, {24'd0, lpat(DEPTH - 1, seed)});
        check("R7 host untouched", {24'd0, hmem[host_off]}, {24'd0, hpat(host_off, seed)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0] b;
        int lens [4] = '{1, 3, 16, 40};
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        buf_wr = 1'b0; buf_addr = '0; buf_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            cfg_read(2'(s), v);
            check("R1 register reset", v, 32'd0);
        end
        check("R1 host_req idle", {31'd0, host_req}, 32'd0);
        check("R1 irq idle", {31'd0, irq_pulse}, 32'd0);

        // R11 chip-side port
        buf_put(17, 8'hA5);
        buf_get(17, b);
        check("R11 buffer port readback", {24'd0, b}, 32'h0000_00A5);

        // main sweep over direction and length
        for (int d = 0; d < 2; d++) begin
            for (int li = 0; li < 4; li++) begin
                int len = lens[li];
                int lo  = (li * 37 + d * 11) % (DEPTH - len);
                int ho  = li * 50 + d * 7;
                run_ok(d[0], li[0], lo, ho, len, li * 3 + d, 1'b0);
            end
        end

        // window that ends exactly at the buffer end is accepted (R7)
        run_ok(1'b1, 1'b1, DEPTH - 8, 300, 8, 9, 1'b0);
        run_ok(1'b0, 1'b0, DEPTH - 5, 600, 5, 10, 1'b0);

        // R4 register freeze during a transfer
        run_ok(1'b0, 1'b1, 20, 400, 32, 11, 1'b1);

        // R10 zero count
        run_ok(1'b1, 1'b1, 4, 100, 0, 12, 1'b0);

        // R7 out-of-window requests
        run_bad(1'b1, BASE - 32'd1, 200, 32'd4, 13);
        run_bad(1'b0, BASE + 32'd250, 210, 32'd7, 14);
        run_bad(1'b1, BASE, 220, 32'd300, 15);

        // next launch clears the error bit (R7)
        run_ok(1'b1, 1'b0, 2, 500, 2, 16, 1'b0);

        // R6 all observed host addresses masked
        check("R6 masked host addresses", 32'(bad_addr), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule